// File: doc/BRIEF.md
# I2C Master SCL Clock Generator with Clock Stretching

This block times the SCL half-periods of an I2C master. A programmable reload value sets the length of each half-period: a down-counter is loaded with it and counts to zero, so every half-period lasts reload+1 system clock cycles. The block drives SCL low for the low half-period. It then releases the line, which is open-drain and wired-AND on the bus, and times the high half-period only while it reads SCL high. A slave that holds the clock low therefore lengthens the cycle. The high phase can never be shortened below one full count.

The master sequencer enables the block and receives a one-cycle tick at every rollover, which it uses to advance SDA. The sequencer can also ask the block to keep SCL low across a rollover, so that it can stall the bus between bytes. A reload value below 2 is rejected: the block raises an error flag and leaves SCL released. The incoming SCL level passes through a parameterised synchronizer. The unstretched SCL period is therefore 2*(reload+1)+SYNC_STAGES cycles. At a 250 MHz system clock, reload values of 1249, 311 and 124 give about 100 kHz, 400 kHz and 1 MHz.

Top module: `scl_clkgen`

## Requirements
- R1: `cfg_err` is 1 exactly when `reload` is 0 or 1. While `cfg_err` is 1, `scl_drive_low` is 0 from the next cycle on and `tick` stays 0, even with `en` high.
- R2: When the block leaves idle with `en` high and a legal reload, it starts by driving SCL low. A low half-period lasts exactly reload+1 cycles.
- R3: After SCL is released, the timer is held at the reload value for as long as the synchronized SCL reads low. The block keeps SCL released and gives no tick, so a slave's stretch adds its own length to the low time seen on the line.
- R4: A high half-period ends only after reload+1 consecutive cycles of synchronized SCL high. The line therefore stays high for reload+1+SYNC_STAGES cycles, whatever the length of any stretch that came before.
- R5: `tick` is a single-cycle pulse in the last cycle of every half-period. There are exactly two ticks per SCL period, and never two ticks in consecutive cycles.
- R6: If `hold_low` is 1 in the last cycle of a low half-period, SCL stays driven low for a further full low half-period, which ends with its own tick.
- R7: When `en` is 0, the block returns to idle on the next cycle: SCL released, no tick. When `en` is raised again, the block restarts with a full low half-period.
- R8: During and after reset, `scl_drive_low` and `tick` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| en | input | 1 | Run request from the master sequencer |
| hold_low | input | 1 | Keep SCL low across the next low-phase rollover |
| reload | input | RLD_W | Half-period count; legal values are 2 and above |
| scl_in | input | 1 | Level read back from the SCL line |
| scl_drive_low | output | 1 | 1 pulls SCL low through the open-drain pad; 0 releases it |
| tick | output | 1 | One-cycle pulse at each half-period rollover |
| cfg_err | output | 1 | Reload value is illegal (0 or 1) |

## Verification
The hardest situation to reach is a slave stretch that starts at the exact moment the block releases SCL, so that the line never shows a high sample that the synchronizer could pass on. The bench models SCL as a wired-AND of the block's drive and a slave model. On the falling clock edge right after it sees the release, the slave pulls the line low for a count taken from the vector table. The same walk then measures the low and high run lengths on the line and counts the ticks inside each period. For a stretched period, the low run must grow by exactly the stretch length, while the high run must keep its unstretched value.

// File: rtl/scl_clkgen_pkg.sv
package scl_clkgen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  localparam int unsigned MIN_RELOAD = 2;

endpackage

// File: rtl/scl_clkgen_sync.sv
module scl_clkgen_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  generate
    if (STAGES == 0) begin : g_pass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0] sr_q;
      logic [STAGES-1:0] sr_d;

      if (STAGES == 1) begin : g_one
        assign sr_d = d;
      end else begin : g_many
        assign sr_d = {sr_q[STAGES-2:0], d};
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sr_q <= {STAGES{RST_VAL}};
        end else begin
          sr_q <= sr_d;
        end
      end

      assign q = sr_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/scl_clkgen_cnt.sv
module scl_clkgen_cnt #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         dec,
  input  logic [W-1:0] reload,
  output logic         zero
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign cnt_en = load | dec;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = reload;
    end else if (dec) begin
      cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/scl_clkgen_fsm.sv
module scl_clkgen_fsm
  import scl_clkgen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run_ok,
  input  logic hold_low,
  input  logic scl_hi,
  input  logic cnt_zero,
  output logic load,
  output logic dec,
  output logic tick,
  output logic drive_low,
  output logic phase_high
);

  phase_e st_q;
  phase_e st_d;

  always_comb begin
    st_d = st_q;
    load = 1'b0;
    dec  = 1'b0;
    tick = 1'b0;
    unique case (st_q)
      PH_IDLE: begin
        if (run_ok) begin
          st_d = PH_LOW;
          load = 1'b1;
        end
      end
      PH_LOW: begin
        if (!run_ok) begin
          st_d = PH_IDLE;
        end else if (cnt_zero) begin
          tick = 1'b1;
          load = 1'b1;
          st_d = hold_low ? PH_LOW : PH_HIGH;
        end else begin
          dec = 1'b1;
        end
      end
      PH_HIGH: begin
        if (!run_ok) begin
          st_d = PH_IDLE;
        end else if (!scl_hi) begin
          load = 1'b1;
        end else if (cnt_zero) begin
          tick = 1'b1;
          load = 1'b1;
          st_d = PH_LOW;
        end else begin
          dec = 1'b1;
        end
      end
      default: begin
        st_d = PH_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PH_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  assign drive_low  = (st_q == PH_LOW);
  assign phase_high = (st_q == PH_HIGH);

endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
  import scl_clkgen_pkg::*;
#(
  parameter int RLD_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             hold_low,
  input  logic [RLD_W-1:0] reload,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             tick,
  output logic             cfg_err
);

  localparam logic [RLD_W-1:0] RLD_MIN = RLD_W'(MIN_RELOAD);

  logic rst_q_n;
  logic scl_hi;
  logic run_ok;
  logic cnt_load;
  logic cnt_dec;
  logic cnt_zero;
  logic phase_high;

  scl_clkgen_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_q_n)
  );

  scl_clkgen_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
    .clk   (clk),
    .rst_n (rst_q_n),
    .d     (scl_in),
    .q     (scl_hi)
  );

  assign cfg_err = (reload < RLD_MIN);
  assign run_ok  = en & ~cfg_err;

  scl_clkgen_cnt #(.W(RLD_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .load   (cnt_load),
    .dec    (cnt_dec),
    .reload (reload),
    .zero   (cnt_zero)
  );

  scl_clkgen_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .run_ok     (run_ok),
    .hold_low   (hold_low),
    .scl_hi     (scl_hi),
    .cnt_zero   (cnt_zero),
    .load       (cnt_load),
    .dec        (cnt_dec),
    .tick       (tick),
    .drive_low  (scl_drive_low),
    .phase_high (phase_high)
  );

endmodule

// File: rtl/scl_clkgen_chk.sv
module scl_clkgen_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic scl_drive_low,
  input logic tick,
  input logic cfg_err,
  input logic scl_s,
  input logic ph_high
);

  logic [15:0] hi_run;
  logic [15:0] lo_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0;
      lo_run <= '0;
    end else begin
      if (!scl_drive_low && scl_s) begin
        hi_run <= (hi_run == 16'hFFFF) ? hi_run : hi_run + 16'd1;
      end else begin
        hi_run <= '0;
      end
      if (scl_drive_low) begin
        lo_run <= (lo_run == 16'hFFFF) ? lo_run : lo_run + 16'd1;
      end else begin
        lo_run <= '0;
      end
    end
  end

  a_r1_err_release: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> !scl_drive_low);

  a_r1_err_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !tick);

  a_r2_min_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_drive_low) && $past(tick)) |-> (lo_run >= 16'd3));

  a_r3_freeze_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_high && en && !cfg_err && !scl_s) |-> !tick);

  a_r3_freeze_released: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_high && en && !cfg_err && !scl_s) |=> !scl_drive_low);

  a_r4_min_high: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ph_high) |-> (hi_run >= 16'd2));

  a_r5_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  a_r7_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_drive_low && !tick));

endmodule

bind scl_clkgen scl_clkgen_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_q_n),
  .en            (en),
  .scl_drive_low (scl_drive_low),
  .tick          (tick),
  .cfg_err       (cfg_err),
  .scl_s         (scl_hi),
  .ph_high       (phase_high)
);

// File: tb/scl_clkgen_test.sv
`timescale 1ns/1ps
module scl_clkgen_test;

  localparam int W  = 12;
  localparam int SY = 2;

  typedef struct packed {
    int rld;
    int str;
    int lo;
    int hi;
  } vec_t;

  // reload, slave stretch, expected low run (R+1+stretch), expected high run (R+1+SY)
  localparam vec_t VECS [0:6] = '{
    '{2,    0, 3,    5},
    '{7,    0, 8,    10},
    '{124,  0, 125,  127},
    '{4095, 0, 4096, 4098},
    '{5,    6, 12,   8},
    '{10,   3, 14,   13},
    '{2,    9, 12,   5}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n;
  logic         en;
  logic         hold_low;
  logic [W-1:0] reload;
  logic         slave_low;
  logic         drv;
  logic         tick;
  logic         cfg_err;
  wire          scl_line = !drv && !slave_low;

  int n_chk  = 0;
  int n_fail = 0;
  int stretch_len = 0;
  int slave_cnt   = 0;
  logic drv_prev  = 1'b0;
  logic tick_prev = 1'b0;
  int   dbl_ticks = 0;
  bit   done = 1'b0;

  scl_clkgen #(.RLD_W(W), .SYNC_STAGES(SY)) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (en),
    .hold_low      (hold_low),
    .reload        (reload),
    .scl_in        (scl_line),
    .scl_drive_low (drv),
    .tick          (tick),
    .cfg_err       (cfg_err)
  );

  initial slave_low = 1'b0;

  // slave model: pulls SCL low right after the master releases it
  always @(negedge clk) begin
    if (drv_prev && !drv && stretch_len > 0) begin
      slave_low = 1'b1;
      slave_cnt = stretch_len;
    end else if (slave_low) begin
      if (slave_cnt > 1) slave_cnt = slave_cnt - 1;
      else slave_low = 1'b0;
    end
    drv_prev = drv;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
    if (tick && tick_prev) dbl_ticks++;
    tick_prev = tick;
  endtask

  task automatic measure(output int lo, output int hi, output int tk);
    lo = 0; hi = 0; tk = 0;
    step();
    while (scl_line) step();
    while (!scl_line) begin
      lo++;
      if (tick) tk++;
      step();
    end
    while (scl_line) begin
      hi++;
      if (tick) tk++;
      step();
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int lo, hi, tk, cnt_drv, cnt_tick;
    rst_n = 1'b0; en = 1'b0; hold_low = 1'b0; reload = W'(2);
    repeat (3) step();
    // R8 reset state
    check("R8 drive in reset", int'(drv), 0);
    check("R8 tick in reset", int'(tick), 0);
    rst_n = 1'b1;
    repeat (4) step();
    check("R8 drive after reset", int'(drv), 0);

    // R1 illegal reload values
    for (int v = 0; v < 2; v++) begin
      reload = W'(v);
      en = 1'b1;
      cnt_drv = 0; cnt_tick = 0;
      for (int i = 0; i < 20; i++) begin
        step();
        if (drv) cnt_drv++;
        if (tick) cnt_tick++;
      end
      check("R1 cfg_err for illegal reload", int'(cfg_err), 1);
      check("R1 SCL held released", cnt_drv, 0);
      check("R1 no tick", cnt_tick, 0);
      en = 1'b0;
      step();
    end
    reload = W'(2);
    step();
    check("R1 cfg_err clear at reload 2", int'(cfg_err), 0);

    // R2 R3 R4 R5 vector walk
    for (int k = 0; k < 7; k++) begin
      en = 1'b0;
      stretch_len = 0;
      repeat (20) step();
      reload = W'(VECS[k].rld);
      stretch_len = VECS[k].str;
      en = 1'b1;
      measure(lo, hi, tk);
      check($sformatf("R2 R3 low run, vector %0d", k), lo, VECS[k].lo);
      check($sformatf("R4 high run, vector %0d", k), hi, VECS[k].hi);
      check($sformatf("R5 ticks per period, vector %0d", k), tk, 2);
      stretch_len = 0;
    end
    en = 1'b0;
    repeat (20) step();
    check("R5 no back-to-back ticks", dbl_ticks, 0);

    // R7 disable mid-phase, then restart
    reload = W'(20);
    en = 1'b1;
    step();
    while (scl_line) step();
    repeat (5) step();
    en = 1'b0;
    step();
    check("R7 released after disable", int'(drv), 0);
    cnt_tick = 0;
    for (int i = 0; i < 30; i++) begin
      step();
      if (tick) cnt_tick++;
    end
    check("R7 no tick while disabled", cnt_tick, 0);
    en = 1'b1;
    measure(lo, hi, tk);
    check("R7 full low phase after restart", lo, 21);
    en = 1'b0;
    repeat (10) step();

    // R6 hold low across one rollover
    reload = W'(5);
    hold_low = 1'b1;
    en = 1'b1;
    step();
    while (scl_line) step();
    lo = 0; tk = 0;
    while (!scl_line) begin
      lo++;
      if (tick) tk++;
      else if (tk == 1) hold_low = 1'b0;
      step();
    end
    check("R6 extended low run", lo, 12);
    check("R6 ticks during held low", tk, 2);
    en = 1'b0;
    repeat (5) step();

    finish_run();
  end

endmodule